// File: doc/BRIEF.md
# Split Gamma Palette with Auto-Increment Loading

This block is a programmable colour lookup memory that sits in a display pixel path. Software loads it through a small register bus. An index register points into the table. A data port writes or reads the entry at that index, and can step the index forward on every access so that a whole table streams in through one address. Each entry packs a 10-bit code for each of red, green and blue.

The table can be used whole or in split mode. In split mode the lower half holds a degamma curve and the upper half holds a gamma curve. Software loads the degamma curve starting at index 0 and the gamma curve starting at the half-size offset. It must then set the index back to 0 before any other writer uses the port. Three 16-bit ceiling registers, one per channel, supply the output for a full-scale input code, which stands for values at or above 1.0.

On the pixel side each channel is looked up on its own with one cycle of latency. The top input bits pick the entry. In split mode a section-select input picks which half is used.

Top module: `gamma_palette`

## Requirements
- R1: After reset the index is 0, auto-increment and split are off, all three ceiling registers read 0xFFFF, and entry i holds i*1023/(DEPTH-1) in every channel field.
- R2: A data word carries red in bits 29:20, green in bits 19:10 and blue in bits 9:0. A write to the data port (address 1) stores bits 29:0 at the current index. A read of the data port returns that entry with bits 31:30 zero.
- R3: When the auto-increment flag (index register bit 31) is set, each data-port write or read advances the index by one after the access. When the flag is clear, the index stays put.
- R4: Auto-increment past entry DEPTH-1 wraps the index to 0.
- R5: A write to the index register (address 0) loads the index from bits [IDX_W-1:0], auto-increment from bit 31 and split from bit 30. A read returns those three fields, with all other bits zero.
- R6: In the variant built with IGNORE_IDX_ON_AINC=1, an index-register write that sets bit 31 updates the flags but leaves the index unchanged, so software must write the index to 0 in a separate step first.
- R7: The ceiling registers for red, green and blue sit at addresses 2, 3 and 4. Each holds the low 16 bits written to it, reads back that value, and changes only on a write to its own address.
- R8: With split off, each pixel channel (12-bit input, red in the top field) below full scale produces its entry's channel field placed in output bits 15:6, with zeros below. The entry is selected by the top 6 input bits, and the result appears one cycle after the input.
- R9: A channel input of all ones produces that channel's ceiling register value, in both split and non-split modes.
- R10: With split on, the entry is {pix_sel, top 5 input bits}. pix_sel=0 reads the degamma half (entries 0..31) and pix_sel=1 reads the gamma half (entries 32..63).
- R11: A pixel lookup of an entry in the same cycle that the data port writes that entry returns the old content. The new content is seen from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (advances the index on a data read) |
| cfg_addr | input | 3 | Register address: 0 index, 1 data, 2/3/4 red/green/blue ceiling |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed register, combinational |
| pix_in | input | 3*PIX_W | Pixel channels, red top, blue bottom |
| pix_sel | input | 1 | Table half used in split mode (0 degamma, 1 gamma) |
| pix_out | output | 3*OUT_W | Looked-up channels, red top, registered |

## Verification
The pixel lookup and a data-port write can land on the same entry in one cycle. The bench provokes this by writing the entry that the pixel input addresses in the same clock. It expects the old entry at the output of that cycle and the new entry from the next lookup on. Random traffic also mixes ceiling-register writes with full-scale inputs, and index reloads with streaming accesses. These are judged against a bench-side shadow of the table, index and flags.

// File: rtl/gpal_pkg.sv
package gpal_pkg;
   typedef enum logic [2:0] {
      RA_INDEX = 3'd0,
      RA_DATA  = 3'd1,
      RA_MAX_R = 3'd2,
      RA_MAX_G = 3'd3,
      RA_MAX_B = 3'd4
   } gpal_reg_e;

   localparam int BUS_W     = 32;
   localparam int AINC_BIT  = 31;
   localparam int SPLIT_BIT = 30;

   // linear ramp code for entry i of a table of depth entries
   function automatic int unsigned ramp_code(input int unsigned i,
                                             input int unsigned depth,
                                             input int unsigned ch_w);
      return (i * ((32'd1 << ch_w) - 1)) / (depth - 1);
   endfunction
endpackage

// File: rtl/gpal_index_ctl.sv
module gpal_index_ctl #(
   parameter int IDX_W              = 6,
   parameter bit IGNORE_IDX_ON_AINC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_ainc,
   input  logic             load_split,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             ainc,
   output logic             split
);
   logic [IDX_W-1:0] next_load;

   generate
      if (IGNORE_IDX_ON_AINC) begin : g_keep_on_ainc
         assign next_load = load_ainc ? idx : load_idx;
      end else begin : g_plain_load
         assign next_load = load_idx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         ainc  <= 1'b0;
         split <= 1'b0;
      end else if (load) begin
         idx   <= next_load;
         ainc  <= load_ainc;
         split <= load_split;
      end else if (step) begin
         idx   <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/gpal_table.sv
module gpal_table #(
   parameter int DEPTH = 64,
   parameter int CH_W  = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [$clog2(DEPTH)-1:0]        wr_addr,
   input  logic [3*CH_W-1:0]               wr_ent,
   input  logic [$clog2(DEPTH)-1:0]        rd_addr,
   output logic [3*CH_W-1:0]               rd_ent,
   input  logic [3*$clog2(DEPTH)-1:0]      lk_addr,
   output logic [9*CH_W-1:0]               lk_ent
);
   import gpal_pkg::*;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int ENT_W = 3 * CH_W;

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= {3{CH_W'(ramp_code(i, DEPTH, CH_W))}};
      end else if (wr_en) begin
         mem[wr_addr] <= wr_ent;
      end
   end

   assign rd_ent = mem[rd_addr];

   generate
      for (genvar g = 0; g < 3; g++) begin : g_lk_port
         assign lk_ent[g*ENT_W +: ENT_W] = mem[lk_addr[g*IDX_W +: IDX_W]];
      end
   endgenerate
endmodule

// File: rtl/gpal_lookup.sv
module gpal_lookup #(
   parameter int PIX_W = 12,
   parameter int IDX_W = 6,
   parameter int CH_W  = 10,
   parameter int OUT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               split,
   input  logic               sel,
   input  logic [3*PIX_W-1:0] pix_in,
   input  logic [9*CH_W-1:0]  lk_ent,
   input  logic [3*OUT_W-1:0] max_flat,
   output logic [3*IDX_W-1:0] lk_addr,
   output logic [3*OUT_W-1:0] pix_out
);
   localparam int ENT_W = 3 * CH_W;
   localparam int PAD_W = OUT_W - CH_W;

   generate
      for (genvar c = 0; c < 3; c++) begin : g_chan
         logic [PIX_W-1:0] v;
         logic [IDX_W-1:0] a;
         logic [CH_W-1:0]  f;

         assign v = pix_in[c*PIX_W +: PIX_W];

         always_comb begin
            if (split) a = {sel, v[PIX_W-1 -: IDX_W-1]};
            else       a = v[PIX_W-1 -: IDX_W];
         end

         assign lk_addr[c*IDX_W +: IDX_W] = a;
         assign f = lk_ent[c*ENT_W + c*CH_W +: CH_W];

         always_ff @(posedge clk) begin
            if (!rst_n)
               pix_out[c*OUT_W +: OUT_W] <= '0;
            else if (&v)
               pix_out[c*OUT_W +: OUT_W] <= max_flat[c*OUT_W +: OUT_W];
            else
               pix_out[c*OUT_W +: OUT_W] <= {f, {PAD_W{1'b0}}};
         end
      end
   endgenerate
endmodule

// File: rtl/gamma_palette.sv
module gamma_palette #(
   parameter int DEPTH              = 64,
   parameter int CH_W               = 10,
   parameter int PIX_W              = 12,
   parameter int OUT_W              = 16,
   parameter bit IGNORE_IDX_ON_AINC = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_re,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic [3*PIX_W-1:0] pix_in,
   input  logic               pix_sel,
   output logic [3*OUT_W-1:0] pix_out
);
   import gpal_pkg::*;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int ENT_W = 3 * CH_W;

   generate
      if (DEPTH != (1 << IDX_W) || DEPTH < 4) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (ENT_W > SPLIT_BIT || OUT_W <= CH_W || OUT_W > 16 + 16) begin : g_bad_width
         $error("channel or output width out of range");
      end
      if (PIX_W < IDX_W) begin : g_bad_pix
         $error("PIX_W must cover the index width");
      end
   endgenerate

   logic [IDX_W-1:0]   idx_q;
   logic               ainc_q, split_q;
   logic [3*OUT_W-1:0] max_q;
   logic [ENT_W-1:0]   rd_ent;
   logic [3*IDX_W-1:0] lk_addr;
   logic [9*CH_W-1:0]  lk_ent;
   logic               data_acc, idx_load, data_wr;

   assign data_acc = (cfg_we || cfg_re) && (cfg_addr == RA_DATA);
   assign data_wr  = cfg_we && (cfg_addr == RA_DATA);
   assign idx_load = cfg_we && (cfg_addr == RA_INDEX);

   gpal_index_ctl #(.IDX_W(IDX_W), .IGNORE_IDX_ON_AINC(IGNORE_IDX_ON_AINC)) u_idx (
      .clk(clk), .rst_n(rst_n),
      .load(idx_load),
      .load_ainc(cfg_wdata[AINC_BIT]),
      .load_split(cfg_wdata[SPLIT_BIT]),
      .load_idx(cfg_wdata[IDX_W-1:0]),
      .step(data_acc && ainc_q),
      .idx(idx_q), .ainc(ainc_q), .split(split_q)
   );

   gpal_table #(.DEPTH(DEPTH), .CH_W(CH_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr), .wr_addr(idx_q), .wr_ent(cfg_wdata[ENT_W-1:0]),
      .rd_addr(idx_q), .rd_ent(rd_ent),
      .lk_addr(lk_addr), .lk_ent(lk_ent)
   );

   gpal_lookup #(.PIX_W(PIX_W), .IDX_W(IDX_W), .CH_W(CH_W), .OUT_W(OUT_W)) u_lk (
      .clk(clk), .rst_n(rst_n),
      .split(split_q), .sel(pix_sel),
      .pix_in(pix_in), .lk_ent(lk_ent), .max_flat(max_q),
      .lk_addr(lk_addr), .pix_out(pix_out)
   );

   // ceiling registers: red top, blue bottom
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         max_q <= {3{{OUT_W{1'b1}}}};
      end else if (cfg_we) begin
         case (cfg_addr)
            RA_MAX_R: max_q[2*OUT_W +: OUT_W] <= cfg_wdata[OUT_W-1:0];
            RA_MAX_G: max_q[1*OUT_W +: OUT_W] <= cfg_wdata[OUT_W-1:0];
            RA_MAX_B: max_q[0 +: OUT_W]       <= cfg_wdata[OUT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RA_INDEX: begin
            cfg_rdata[AINC_BIT]    = ainc_q;
            cfg_rdata[SPLIT_BIT]   = split_q;
            cfg_rdata[IDX_W-1:0]   = idx_q;
         end
         RA_DATA:  cfg_rdata[ENT_W-1:0] = rd_ent;
         RA_MAX_R: cfg_rdata[OUT_W-1:0] = max_q[2*OUT_W +: OUT_W];
         RA_MAX_G: cfg_rdata[OUT_W-1:0] = max_q[1*OUT_W +: OUT_W];
         RA_MAX_B: cfg_rdata[OUT_W-1:0] = max_q[0 +: OUT_W];
         default: ;
      endcase
   end
endmodule

// File: rtl/gpal_chk.sv
module gpal_chk #(
   parameter int IDX_W = 6,
   parameter int PIX_W = 12,
   parameter int OUT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic               cfg_re,
   input logic [2:0]         cfg_addr,
   input logic [31:0]        cfg_wdata,
   input logic [IDX_W-1:0]   idx,
   input logic               ainc,
   input logic [PIX_W-1:0]   red_in,
   input logic [OUT_W-1:0]   red_out,
   input logic [OUT_W-1:0]   red_max,
   input logic [3*OUT_W-1:0] max_all
);
   logic acc;
   assign acc = (cfg_we || cfg_re) && (cfg_addr == 3'd1);

   // R3
   idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ainc) |=> (idx == $past(idx) + 1'b1));

   // R4
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ainc && (&idx)) |=> (idx == '0));

   // R3
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ainc) |=> $stable(idx));

   // R5
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 3'd0 && !cfg_wdata[31]) |=> (idx == $past(cfg_wdata[IDX_W-1:0])));

   // R7
   max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr >= 3'd2 && cfg_addr <= 3'd4) |=> $stable(max_all));

   // R9
   full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&red_in) |=> (red_out == $past(red_max)));
endmodule

bind gamma_palette gpal_chk #(.IDX_W(IDX_W), .PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .idx(idx_q), .ainc(ainc_q),
   .red_in(pix_in[3*PIX_W-1 -: PIX_W]),
   .red_out(pix_out[3*OUT_W-1 -: OUT_W]),
   .red_max(max_q[3*OUT_W-1 -: OUT_W]),
   .max_all(max_q)
);

// File: tb/sim_gamma_palette.sv
module sim_gamma_palette;
   localparam int CLK_P = 10;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we0 = 0, re0 = 0, we1 = 0, re1 = 0;
   logic [2:0]  ad0 = 0, ad1 = 0;
   logic [31:0] wd0 = 0, wd1 = 0;
   logic [31:0] rd0, rd1;
   logic [35:0] pin = '0;
   logic        psel = 1'b0;
   logic [47:0] pout, pout1;

   int n_chk = 0, n_err = 0;

   logic [29:0] model [DEPTH];
   int          m_idx;
   bit          m_ainc, m_split;
   logic [15:0] m_max [3];

   always #(CLK_P/2) clk = ~clk;

   gamma_palette u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we0), .cfg_re(re0), .cfg_addr(ad0),
      .cfg_wdata(wd0), .cfg_rdata(rd0), .pix_in(pin), .pix_sel(psel), .pix_out(pout));

   gamma_palette #(.IGNORE_IDX_ON_AINC(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we1), .cfg_re(re1), .cfg_addr(ad1),
      .cfg_wdata(wd1), .cfg_rdata(rd1), .pix_in(36'd0), .pix_sel(1'b0), .pix_out(pout1));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start just after a falling edge and end on the next one
   task automatic bus_wr(input bit u, input logic [2:0] a, input logic [31:0] d);
      if (u) begin we1 = 1; ad1 = a; wd1 = d; end
      else   begin we0 = 1; ad0 = a; wd0 = d; end
      @(negedge clk);
      we0 = 0; we1 = 0;
   endtask

   task automatic bus_rd(input bit u, input logic [2:0] a, output logic [31:0] d);
      if (u) begin re1 = 1; ad1 = a; end
      else   begin re0 = 1; ad0 = a; end
      #1 d = u ? rd1 : rd0;
      @(negedge clk);
      re0 = 0; re1 = 0;
   endtask

   function automatic int ramp(input int i);
      return (i * 1023) / (DEPTH - 1);
   endfunction

   function automatic logic [15:0] exp_px(input int c, input logic [11:0] v, input bit sel);
      logic [5:0] a;
      if (v == 12'hFFF) return m_max[c];
      a = m_split ? {sel, v[11:7]} : v[11:6];
      return {model[a][c*10 +: 10], 6'b0};
   endfunction

   // model-side register operations
   task automatic m_wr_index(input bit ai, input bit sp, input logic [29:0] mid);
      bus_wr(0, 3'd0, {ai, sp, mid});
      m_ainc = ai; m_split = sp; m_idx = int'(mid[5:0]);
   endtask

   task automatic m_wr_data(input logic [31:0] d, input string req);
      bus_wr(0, 3'd1, d);
      model[m_idx] = d[29:0];
      if (m_ainc) m_idx = (m_idx + 1) % DEPTH;
   endtask

   task automatic m_rd_data(input string req);
      logic [31:0] d;
      logic [31:0] e;
      e = {2'b00, model[m_idx]};
      bus_rd(0, 3'd1, d);
      chk(req, d, e);
      if (m_ainc) m_idx = (m_idx + 1) % DEPTH;
   endtask

   task automatic m_rd_index(input string req);
      logic [31:0] d;
      bus_rd(0, 3'd0, d);
      chk(req, d, {m_ainc, m_split, 24'd0, 6'(m_idx)});
   endtask

   task automatic m_px(input logic [35:0] p, input bit sel, input string req);
      logic [47:0] e;
      for (int c = 0; c < 3; c++) e[c*16 +: 16] = exp_px(c, p[c*12 +: 12], sel);
      pin = p; psel = sel;
      @(negedge clk);
      chk(req, pout, e);
   endtask

   function automatic logic [11:0] rnd_ch();
      return ($urandom_range(0, 7) == 0) ? 12'hFFF : 12'($urandom);
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_0C4A));
      for (int i = 0; i < DEPTH; i++) begin
         logic [9:0] r;
         r = 10'(ramp(i));
         model[i] = {r, r, r};
      end
      m_idx = 0; m_ainc = 0; m_split = 0;
      for (int c = 0; c < 3; c++) m_max[c] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      m_rd_index("R1 index after reset");
      bus_rd(0, 3'd2, d); chk("R1 red ceiling", d, 32'hFFFF);
      bus_rd(0, 3'd3, d); chk("R1 green ceiling", d, 32'hFFFF);
      bus_rd(0, 3'd4, d); chk("R1 blue ceiling", d, 32'hFFFF);
      m_wr_index(1, 0, 30'd0);
      for (int i = 0; i < DEPTH; i++) m_rd_data("R1 linear entry");
      // R4 wrap after reading every entry
      m_rd_index("R4 index wrapped to 0");

      // R2 packing and R3 hold without auto-increment
      m_wr_index(0, 0, 30'd10);
      m_wr_data({2'b11, 10'h3AB, 10'h155, 10'h2C3}, "R2");
      m_rd_data("R2 packed readback");
      m_rd_index("R3 index held without auto-increment");
      m_px({12'h3AB & 12'h000 | 12'(10 << 6), 12'(10 << 6) | 12'h3F, 12'(10 << 6)}, 0,
           "R8 lookup of written entry");

      // R4 wrap on write
      m_wr_index(1, 0, 30'd63);
      m_wr_data(32'h0ABC_DEF1, "R4");
      m_rd_index("R4 write wraps to 0");

      // R10 split load: degamma half then gamma half, then index back to 0 (R5)
      m_wr_index(1, 1, 30'd0);
      for (int i = 0; i < DEPTH; i++) m_wr_data($urandom, "R10");
      m_wr_index(0, 1, 30'd0);
      m_rd_index("R5 index cleared after split load");
      for (int k = 0; k < 6; k++)
         m_px({12'($urandom), 12'($urandom), 12'($urandom)}, k[0], "R10 split lookup");

      // R9 full scale with new ceilings
      bus_wr(0, 3'd2, 32'hFFFF_1234); m_max[2] = 16'h1234;
      bus_wr(0, 3'd4, 32'h0000_0BCD); m_max[0] = 16'h0BCD;
      bus_rd(0, 3'd2, d); chk("R7 red ceiling readback", d, 32'h1234);
      m_px({12'hFFF, 12'hFFF, 12'hFFF}, 1, "R9 full scale split");
      m_wr_index(0, 0, 30'd0);
      m_px({12'hFFF, 12'hFFE, 12'hFFF}, 0, "R9 full scale plain");

      // R11 write and lookup of entry 20 in one cycle
      m_wr_index(0, 0, 30'd20);
      begin
         logic [47:0] e_old, e_new;
         logic [35:0] p;
         p = {3{12'((20 << 6) | 5)}};
         for (int c = 0; c < 3; c++) e_old[c*16 +: 16] = exp_px(c, p[c*12 +: 12], 0);
         we0 = 1; ad0 = 3'd1; wd0 = 32'h1555_2AAA; pin = p; psel = 0;
         @(negedge clk);
         we0 = 0;
         chk("R11 same-cycle lookup sees old entry", pout, e_old);
         model[20] = 30'h1555_2AAA;
         for (int c = 0; c < 3; c++) e_new[c*16 +: 16] = exp_px(c, p[c*12 +: 12], 0);
         @(negedge clk);
         chk("R11 next lookup sees new entry", pout, e_new);
      end

      // R6 variant: index bits ignored when auto-increment is set
      bus_wr(1, 3'd0, 32'd5);
      bus_wr(1, 3'd0, 32'h8000_0009);
      bus_rd(1, 3'd0, d); chk("R6 index kept on auto-increment load", d, 32'h8000_0005);
      bus_wr(1, 3'd1, 32'h0000_0001);
      bus_rd(1, 3'd0, d); chk("R6 variant still advances", d, 32'h8000_0006);

      // random mix across R2 R3 R5 R7 R8 R9 R10
      for (int n = 0; n < 600; n++) begin
         case ($urandom_range(0, 6))
            0: m_wr_index(1'($urandom), 1'($urandom), 30'($urandom));
            1: m_wr_data($urandom, "R2");
            2: m_rd_data("R3 random data read");
            3: m_rd_index("R5 random index read");
            4: begin
               int a;
               logic [31:0] w;
               a = $urandom_range(2, 4);
               w = $urandom;
               bus_wr(0, 3'(a), w);
               m_max[4 - a] = w[15:0];
               bus_rd(0, 3'(a), d);
               chk("R7 random ceiling", d, {16'd0, w[15:0]});
            end
            default: m_px({rnd_ch(), rnd_ch(), rnd_ch()}, 1'($urandom),
                          m_split ? "R10 random split lookup" : "R8 random lookup");
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule